// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

This block watches a serial bit stream and cuts it into back-to-back groups of four bits. The groups never overlap. Each bit counts only in a cycle where its qualifying strobe is high. When the fourth bit of a group arrives, the block compares the whole group with two fixed target words. If the group equals either word, it raises its match output in that same cycle.

After every fourth bit the block goes back to its start state, whether or not the group matched. A pattern that straddles two groups is therefore never reported. A sliding search over the stream would find such a pattern; this block does not.

The controller is a small Mealy machine. Its states have been reduced by merging equivalent ones, which leaves seven states. The first bit of a group that arrives is treated as the leftmost bit of the target word. The two target words are `0110` and `1010`, written in arrival order.

Top module: `quad_frame_detect`

## Requirements
- R1: When the four accepted bits of a group, taken in arrival order with the first bit leftmost, spell `0110`, `match_out` is 1 in the cycle that accepts the fourth bit.
- R2: When the four accepted bits of a group, taken in arrival order, spell `1010`, `match_out` is 1 in the cycle that accepts the fourth bit.
- R3: For every one of the other fourteen four-bit groups, `match_out` stays 0 throughout the group.
- R4: Groups are consecutive and disjoint. After the fourth accepted bit, the next accepted bit starts a fresh group. A target word that spans two groups (for example, the stream `1011` `0100`) never raises `match_out`.
- R5: In a cycle with `bit_vld` = 0, `bit_in` is ignored and the position within the group does not advance.
- R6: `match_out` is 0 in every cycle where `bit_vld` is 0, and in every cycle that accepts the first, second or third bit of a group.
- R7: While `rst_n` is 0 at a rising clock edge, the block returns to the first position of a group. `match_out` is 0 in every cycle where `rst_n` is 0, even if the inputs would otherwise complete a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | High when `bit_in` carries a bit to be accepted |
| bit_in | input | 1 | Serial data bit |
| match_out | output | 1 | Mealy match flag, high in the cycle that accepts the fourth bit of a matching group |

## Verification
The block has no tunable parameters, so the bench builds it with its fixed pattern pair and seven-state encoding. With that build, the bench can drive all sixteen possible groups directly. It also runs group streams in which the strobe has gaps, a stream where a target word crosses a group boundary, and resets that arrive partway through a group. On top of these, it drives long random streams in which resets and strobe gaps fall at every position within a group.

// File: rtl/fgd_pkg.sv
// Package: shared state encoding for the framed four-bit detector.
// Assumes: a 3-bit register is enough for the seven merged states.
package fgd_pkg;

    localparam int unsigned GROUP_LEN = 4;
    localparam int unsigned STATE_W   = 3;

    // State names record how far a group has progressed.
    // LIVE  : the bits so far can still end in a match.
    // DEAD  : the group can no longer match.
    // HEAD0 / HEAD1 : one bit seen, 0 or 1 respectively.
    typedef enum logic [STATE_W-1:0] {
        ST_START = 3'd0,
        ST_HEAD0 = 3'd1,
        ST_HEAD1 = 3'd2,
        ST_LIVE2 = 3'd3,
        ST_DEAD2 = 3'd4,
        ST_LIVE3 = 3'd5,
        ST_DEAD3 = 3'd6
    } fgd_state_e;

endpackage

// File: rtl/qfd_next_state.sv
// Module: next-state logic of the reduced detector.
// Assumes: the register holds its value when the strobe is low, so this
// module returns the current state whenever vld is 0.
module qfd_next_state
    import fgd_pkg::*;
(
    input  fgd_state_e cur_state,
    input  logic       vld,
    input  logic       din,
    output fgd_state_e nxt_state
);

    // Purpose: step through one group position per accepted bit.
    always_comb begin
        nxt_state = cur_state;
        if (vld) begin
            unique case (cur_state)
                ST_START: nxt_state = din ? ST_HEAD1 : ST_HEAD0;
                ST_HEAD0: nxt_state = din ? ST_LIVE2 : ST_DEAD2;
                ST_HEAD1: nxt_state = din ? ST_DEAD2 : ST_LIVE2;
                ST_LIVE2: nxt_state = din ? ST_LIVE3 : ST_DEAD3;
                ST_DEAD2: nxt_state = ST_DEAD3;
                ST_LIVE3: nxt_state = ST_START;
                ST_DEAD3: nxt_state = ST_START;
                default:  nxt_state = ST_START;
            endcase
        end
    end

endmodule

// File: rtl/qfd_match_out.sv
// Module: Mealy output decode.
// Assumes: both target words end in 0, so a live third-position state
// together with an accepted 0 completes a match.
module qfd_match_out
    import fgd_pkg::*;
(
    input  fgd_state_e cur_state,
    input  logic       vld,
    input  logic       din,
    input  logic       rst_n,
    output logic       hit
);

    // Purpose: flag a completed matching group; forced low during reset.
    always_comb begin
        hit = rst_n && vld && (cur_state == ST_LIVE3) && !din;
    end

endmodule

// File: rtl/quad_frame_detect.sv
// Module: top of the framed four-bit pattern detector.
// Splits the stream of accepted bits into disjoint four-bit groups and
// flags a group equal to 0110 or 1010 (first bit leftmost).
// Assumes: a synchronous active-low reset; bit_vld qualifies bit_in.
module quad_frame_detect
    import fgd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic match_out
);

    fgd_state_e state_q;
    fgd_state_e state_d;

    qfd_next_state u_next (
        .cur_state (state_q),
        .vld       (bit_vld),
        .din       (bit_in),
        .nxt_state (state_d)
    );

    qfd_match_out u_out (
        .cur_state (state_q),
        .vld       (bit_vld),
        .din       (bit_in),
        .rst_n     (rst_n),
        .hit       (match_out)
    );

    // Purpose: state register with synchronous reset to the group start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/qfd_checker.sv
// Module: property checker for quad_frame_detect.
// Keeps its own count of group position and group history, and compares
// the design's output and state register against them.
module qfd_checker
    import fgd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bit_vld,
    input logic               bit_in,
    input logic               match_out,
    input logic [STATE_W-1:0] state_q
);

    logic [1:0] pos_q;
    logic [2:0] hist_q;
    logic [3:0] grp_w;

    assign grp_w = {hist_q, bit_in};

    // Purpose: independent group position and bit history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= 2'd0;
            hist_q <= 3'd0;
        end else if (bit_vld) begin
            pos_q  <= pos_q + 2'd1;
            hist_q <= {hist_q[1:0], bit_in};
        end
    end

    // R1 / R2 / R3: output equals the framed-match condition
    assert_match_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_out == (bit_vld && pos_q == 2'd3 &&
                      (grp_w == 4'b0110 || grp_w == 4'b1010)));

    // R1 and R2: both words end in 0
    assert_match_last_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        match_out |-> !bit_in);

    // R4: a completed group sends the machine back to its start state
    assert_group_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && pos_q == 2'd3) |=> (state_q == ST_START));

    // R5: the state register holds when no bit is offered
    assert_hold_no_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(state_q));

    // R6: no match without a strobe
    assert_match_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_out |-> bit_vld);

    // R7: reset forces the output low
    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |-> !match_out);

    // R7: reset returns the machine to the first position
    assert_reset_start_R7: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_START));

endmodule

bind quad_frame_detect qfd_checker i_qfd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .match_out (match_out),
    .state_q   (state_q)
);

// File: tb/test_quad_frame_detect.sv
module test_quad_frame_detect;

    logic clk = 1'b0;
    logic rst_n;
    logic bit_vld;
    logic bit_in;
    logic match_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    int       m_pos  = 0;
    logic [2:0] m_hist = 3'd0;

    always #2.5 clk = ~clk;

    quad_frame_detect i_quad_frame_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .match_out (match_out)
    );

    function automatic logic exp_match(logic r, logic v, logic x, int pos, logic [2:0] h);
        logic [3:0] g;
        g = {h, x};
        return r && v && (pos == 3) && (g == 4'b0110 || g == 4'b1010);
    endfunction

    function automatic string pick_tag(logic r, logic v, logic x, int pos, logic [2:0] h);
        if (!r) return "R7";
        if (!v) return "R5";
        if (pos != 3) return "R6";
        if ({h, x} == 4'b0110) return "R1";
        if ({h, x} == 4'b1010) return "R2";
        return "R3";
    endfunction

    // one cycle: drive at negedge, check 1 ns later, advance the model
    task automatic step(input logic r, input logic v, input logic x, input string tag);
        logic e;
        string t;
        @(negedge clk);
        rst_n   = r;
        bit_vld = v;
        bit_in  = x;
        #1;
        e = exp_match(r, v, x, m_pos, m_hist);
        t = (tag == "") ? pick_tag(r, v, x, m_pos, m_hist) : tag;
        tests++;
        if (match_out !== e) begin
            fails++;
            $display("FAIL %s: match_out=%b expected=%b (pos=%0d)", t, match_out, e, m_pos);
        end
        if (!r) begin
            m_pos  = 0;
            m_hist = 3'd0;
        end else if (v) begin
            m_hist = {m_hist[1:0], x};
            m_pos  = (m_pos + 1) % 4;
        end
    endtask

    task automatic send_group(input logic [3:0] g, input string tag);
        for (int i = 3; i >= 0; i--) step(1'b1, 1'b1, g[i], tag);
    endtask

    initial begin
        void'($urandom(32'd20110112));
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
        // R7: reset state, output low while held
        step(1'b0, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b1, "R7");

        // R1, R2, R3: every possible group
        for (int g = 0; g < 16; g++) send_group(4'(g), "");

        // R4: a 0110 that straddles a group boundary is not reported
        send_group(4'b1011, "R4");
        send_group(4'b0100, "R4");
        send_group(4'b0110, "R4");
        send_group(4'b0110, "R4");

        // R5: gaps inside a group, with bit_in toggling while ignored
        step(1'b1, 1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R2");

        // R7: reset mid-group with a would-be matching fourth bit
        step(1'b1, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b1, 1'b1, "R7");
        step(1'b1, 1'b1, 1'b1, "R7");
        step(1'b0, 1'b1, 1'b0, "R7");
        send_group(4'b0110, "R7");

        // random stream with gaps and rare resets
        for (int n = 0; n < 4000; n++) begin
            logic r, v, x;
            r = ($urandom % 150) != 0;
            v = ($urandom % 4) != 0;
            x = $urandom % 2;
            step(r, v, x, "");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule